// File: doc/BRIEF.md
# Edge-Armed Byte Word Aligner

This block takes a receive stream that arrives one byte per clock with no known byte boundary. It watches the stream for a fixed 16-bit alignment pattern at every one of the eight possible bit offsets. Once it finds the pattern, it sends out the bytes regrouped on the boundary the pattern defines.

Alignment is armed by a rising edge on an enable input. The first pattern seen after arming fixes the bit offset and uses up the arm. Later patterns at the same offset are reported, and patterns at any other offset are ignored until the enable falls and rises again.

Two one-clock status pulses travel through the same register stage as the output byte. A sync pulse marks a new lock. A pattern pulse marks every pattern found on the current boundary. Both coincide with the pattern's upper byte on the output.

Top module: `byte_word_aligner`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `aligned_byte`, `sync_pulse` and `pat_pulse` are all zero, and the bit offset is 0.
- R2: Before any lock, the offset is 0 and `aligned_byte` equals the `rx_byte` value presented two clock edges earlier.
- R3: Bits are numbered LSB-first within each received byte, and earlier bytes come first. At offset k, each output byte is bits [k+7:k] of {later byte, earlier byte}.
- R4: The pattern is 16'h28F6, with 8'hF6 received first. When armed, the first pattern found at any offset k makes k the new offset. One clock later, `sync_pulse` and `pat_pulse` are both high for one cycle while `aligned_byte` shows 8'h28.
- R5: A pattern found at the locked offset gives one cycle of `pat_pulse` alone, in the cycle where `aligned_byte` shows 8'h28.
- R6: A pattern at a different offset with no rising edge of `align_en` since the last lock changes neither the offset nor any status output.
- R7: A lock disarms the block. Holding `align_en` high after a lock does not allow a second realignment.
- R8: Driving `align_en` low and then high re-arms the block. The next pattern at any offset, including the current one, locks again with both pulses.
- R9: A reset in mid-stream returns the offset to 0. A byte-aligned pattern received afterwards while unarmed pulses `pat_pulse` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Unaligned received byte, one per clock |
| align_en | input | 1 | Alignment enable; a rising edge arms one lock |
| aligned_byte | output | 8 | Byte realigned to the locked bit offset |
| sync_pulse | output | 1 | One-cycle pulse on a new lock |
| pat_pulse | output | 1 | One-cycle pulse on any pattern at the output boundary |

## Verification
The hardest state to reach from the ports is a pattern at a foreign offset arriving while the block is disarmed but the enable is still high. Only a correct disarm on lock keeps that pattern from moving the boundary. The stimulus locks to offset 3 and holds `align_en` high. It then injects the pattern shifted to offset 6, drops the enable without raising it again, and injects the pattern at offset 5. Only after a clean low-to-high edge does it send offset 6 again and expect a realignment.

// File: rtl/wa_pkg.sv
package wa_pkg;

  typedef struct packed {
    logic sync;
    logic pat;
  } wa_status_t;

  localparam int unsigned WA_HIST = 2;

endpackage

// File: rtl/wa_arm_ctrl.sv
module wa_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lock_i,
  output logic armed_o
);

  logic en_q;
  logic armed_q;
  logic armed_d;
  logic rise;

  assign rise = en_i & ~en_q;

  always_comb begin
    armed_d = armed_q;
    if (rise) begin
      armed_d = 1'b1;
    end else if (lock_i) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q    <= en_i;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

endmodule

// File: rtl/wa_window.sv
module wa_window #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HIST   = wa_pkg::WA_HIST,
  localparam int unsigned WIN_W = (HIST + 1) * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WIN_W-1:0]  win_o
);

  logic [BYTE_W-1:0] stage_q [HIST];

  generate
    for (genvar i = 0; i < HIST; i++) begin : g_stage
      logic [BYTE_W-1:0] src;
      if (i == 0) begin : g_first
        assign src = byte_i;
      end else begin : g_next
        assign src = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[i] <= '0;
        end else begin
          stage_q[i] <= src;
        end
      end
      assign win_o[(HIST-1-i)*BYTE_W +: BYTE_W] = stage_q[i];
    end
  endgenerate

  assign win_o[HIST*BYTE_W +: BYTE_W] = byte_i;

endmodule

// File: rtl/wa_match_bank.sv
module wa_match_bank #(
  parameter int unsigned BYTE_W  = 8,
  parameter logic [2*BYTE_W-1:0] PATTERN = 16'h28F6,
  localparam int unsigned WIN_W  = 3 * BYTE_W,
  localparam int unsigned NOFF   = BYTE_W,
  localparam int unsigned OFF_W  = $clog2(BYTE_W)
) (
  input  logic [WIN_W-1:0] win_i,
  output logic [NOFF-1:0]  hit_o,
  output logic             any_o,
  output logic [OFF_W-1:0] first_o
);

  generate
    for (genvar k = 0; k < NOFF; k++) begin : g_cmp
      assign hit_o[k] = (win_i[k +: 2*BYTE_W] == PATTERN);
    end
  endgenerate

  always_comb begin
    first_o = '0;
    for (int k = NOFF - 1; k >= 0; k--) begin
      if (hit_o[k]) begin
        first_o = OFF_W'(k);
      end
    end
  end

  assign any_o = |hit_o;

endmodule

// File: rtl/wa_byte_sel.sv
module wa_byte_sel #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WIN_W = 3 * BYTE_W,
  localparam int unsigned NOFF  = BYTE_W,
  localparam int unsigned OFF_W = $clog2(BYTE_W)
) (
  input  logic [WIN_W-1:0]  win_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [BYTE_W-1:0] byte_o
);

  logic [BYTE_W-1:0] cand [NOFF];

  generate
    for (genvar k = 0; k < NOFF; k++) begin : g_cand
      assign cand[k] = win_i[k + BYTE_W +: BYTE_W];
    end
  endgenerate

  assign byte_o = cand[off_i];

endmodule

// File: rtl/byte_word_aligner.sv
module byte_word_aligner #(
  parameter int unsigned BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] PATTERN = 16'h28F6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              align_en,
  output logic [BYTE_W-1:0] aligned_byte,
  output logic              sync_pulse,
  output logic              pat_pulse
);

  localparam int unsigned WIN_W = 3 * BYTE_W;
  localparam int unsigned NOFF  = BYTE_W;
  localparam int unsigned OFF_W = $clog2(BYTE_W);

  logic [WIN_W-1:0]  win;
  logic [NOFF-1:0]   hit;
  logic              any_hit;
  logic [OFF_W-1:0]  first_off;
  logic              armed;
  logic              lock;
  logic              off_en;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  off_d;
  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-1:0] data_q;
  wa_pkg::wa_status_t stat_d;
  wa_pkg::wa_status_t stat_q;

  wa_window #(.BYTE_W(BYTE_W), .HIST(2)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .byte_i (rx_byte),
    .win_o  (win)
  );

  wa_match_bank #(.BYTE_W(BYTE_W), .PATTERN(PATTERN)) u_match (
    .win_i   (win),
    .hit_o   (hit),
    .any_o   (any_hit),
    .first_o (first_off)
  );

  wa_arm_ctrl u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (align_en),
    .lock_i  (lock),
    .armed_o (armed)
  );

  assign lock   = armed & any_hit;
  assign off_en = lock;

  always_comb begin
    off_d = off_q;
    if (off_en) begin
      off_d = first_off;
    end
  end

  wa_byte_sel #(.BYTE_W(BYTE_W)) u_sel (
    .win_i  (win),
    .off_i  (off_d),
    .byte_o (sel_byte)
  );

  always_comb begin
    stat_d.sync = lock;
    stat_d.pat  = lock | hit[off_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      stat_q <= '0;
    end else begin
      data_q <= sel_byte;
      stat_q <= stat_d;
    end
  end

  assign aligned_byte = data_q;
  assign sync_pulse   = stat_q.sync;
  assign pat_pulse    = stat_q.pat;

endmodule

// File: rtl/byte_word_aligner_checker.sv
module byte_word_aligner_checker #(
  parameter int unsigned BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] PATTERN = 16'h28F6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              align_en,
  input logic [BYTE_W-1:0] aligned_byte,
  input logic              sync_pulse,
  input logic              pat_pulse
);

  logic en_seen_q;
  logic rise_q;
  logic arm_seen_q;
  logic rise_now;

  assign rise_now = align_en & ~en_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_seen_q  <= 1'b0;
      rise_q     <= 1'b0;
      arm_seen_q <= 1'b0;
    end else begin
      en_seen_q <= align_en;
      rise_q    <= rise_now;
      if (rise_now || rise_q) begin
        arm_seen_q <= 1'b1;
      end else if (sync_pulse) begin
        arm_seen_q <= 1'b0;
      end
    end
  end

  AST_SYNC_WITH_PAT: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> pat_pulse); // R4

  AST_SYNC_ON_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> (aligned_byte == PATTERN[2*BYTE_W-1:BYTE_W])); // R4

  AST_PAT_ON_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    pat_pulse |-> (aligned_byte == PATTERN[2*BYTE_W-1:BYTE_W])); // R5

  AST_SYNC_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> arm_seen_q); // R6

endmodule

bind byte_word_aligner byte_word_aligner_checker #(
  .BYTE_W(BYTE_W),
  .PATTERN(PATTERN)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .align_en     (align_en),
  .aligned_byte (aligned_byte),
  .sync_pulse   (sync_pulse),
  .pat_pulse    (pat_pulse)
);

// File: tb/byte_word_aligner_bench.sv
module byte_word_aligner_bench;

  localparam logic [15:0] PAT = 16'h28F6;

  logic       clk;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       align_en;
  logic [7:0] aligned_byte;
  logic       sync_pulse;
  logic       pat_pulse;

  byte_word_aligner u_byte_word_aligner (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_byte      (rx_byte),
    .align_en     (align_en),
    .aligned_byte (aligned_byte),
    .sync_pulse   (sync_pulse),
    .pat_pulse    (pat_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] data;
    logic       sync;
    logic       pat;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] hist[$];
  int         n_run;
  int         n_fail;
  int         m_off;
  bit         m_armed;
  bit         m_en_prev;
  string      cur_tag;
  bit         done;

  function automatic bit sbit(int idx);
    return hist[idx / 8][idx % 8];
  endfunction

  function automatic logic [15:0] bits16(int p);
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = sbit(p + i);
    return v;
  endfunction

  function automatic logic [7:0] bits8(int p);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = sbit(p + i);
    return v;
  endfunction

  task automatic drive_now(input logic [7:0] b, input logic en);
    exp_t e;
    int   j;
    bit   rise;
    bit   lock;
    bit   curhit;
    int   newk;
    rx_byte  = b;
    align_en = en;
    hist.push_back(b);
    j = hist.size() - 1;
    rise = en && !m_en_prev;
    m_en_prev = en;
    lock = 1'b0;
    newk = m_off;
    if (m_armed) begin
      for (int k = 7; k >= 0; k--) begin
        if (bits16(8 * (j - 2) + k) == PAT) begin
          lock = 1'b1;
          newk = k;
        end
      end
    end
    curhit = (bits16(8 * (j - 2) + m_off) == PAT);
    e.sync = lock;
    e.pat  = lock | curhit;
    m_off  = newk;
    e.data = bits8(8 * (j - 1) + m_off);
    e.tag  = cur_tag;
    if (rise) m_armed = 1'b1;
    else if (lock) m_armed = 1'b0;
    sb_q.push_back(e);
  endtask

  task automatic drive(input logic [7:0] b, input logic en);
    @(negedge clk);
    drive_now(b, en);
  endtask

  task automatic send_pattern(input int k, input logic en);
    logic [23:0] v;
    v = 24'(PAT) << k;
    drive(v[7:0], en);
    drive(v[15:8], en);
    drive(v[23:16], en);
  endtask

  task automatic idle(input int n, input logic en);
    for (int i = 0; i < n; i++) drive(8'h00, en);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    rx_byte  = 8'h00;
    align_en = 1'b0;
    repeat (3) @(negedge clk);
    n_run++;
    if (aligned_byte !== 8'h00 || sync_pulse !== 1'b0 || pat_pulse !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: outputs in reset data=%h sync=%b pat=%b expected data=00 sync=0 pat=0",
               aligned_byte, sync_pulse, pat_pulse);
    end
    sb_q.delete();
    hist.delete();
    hist.push_back(8'h00);
    hist.push_back(8'h00);
    m_off     = 0;
    m_armed   = 1'b0;
    m_en_prev = 1'b0;
    cur_tag   = "R1";
    @(negedge clk);
    rst_n = 1'b1;
    drive_now(8'h00, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_run++;
        if (aligned_byte !== e.data || sync_pulse !== e.sync || pat_pulse !== e.pat) begin
          n_fail++;
          $display("FAIL %s: data=%h sync=%b pat=%b expected data=%h sync=%b pat=%b",
                   e.tag, aligned_byte, sync_pulse, pat_pulse, e.data, e.sync, e.pat);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    rx_byte = 8'h00;
    align_en = 1'b0;
    do_reset();
    idle(2, 1'b0);

    // R2: unaligned traffic before any lock, offset 0, two-clock lag
    cur_tag = "R2";
    for (int i = 0; i < 24; i++) drive(8'($urandom_range(0, 255)), 1'b0);

    // R6: pattern at offset 4 while never armed is ignored
    cur_tag = "R6";
    send_pattern(4, 1'b0);
    idle(3, 1'b0);

    // R4: arm with a rising edge, then pattern at offset 3 locks
    cur_tag = "R4";
    idle(2, 1'b1);
    send_pattern(3, 1'b1);
    idle(2, 1'b1);

    // R3: data regrouped at offset 3
    cur_tag = "R3";
    for (int i = 0; i < 12; i++) drive(8'($urandom_range(0, 255)), 1'b1);

    // R5: pattern again at the locked offset gives pat only
    cur_tag = "R5";
    send_pattern(3, 1'b1);
    idle(3, 1'b1);

    // R7: enable still high after lock, pattern at offset 6 ignored
    cur_tag = "R7";
    send_pattern(6, 1'b1);
    idle(3, 1'b1);

    // R6: enable dropped but not raised, pattern at offset 5 ignored
    cur_tag = "R6";
    idle(2, 1'b0);
    send_pattern(5, 1'b0);
    idle(3, 1'b0);

    // R8: low then high re-arms, offset 6 pattern realigns
    cur_tag = "R8";
    idle(1, 1'b1);
    send_pattern(6, 1'b1);
    idle(3, 1'b1);
    for (int i = 0; i < 8; i++) drive(8'($urandom_range(0, 255)), 1'b1);

    // R8: re-arm and lock again at the same offset
    idle(2, 1'b0);
    idle(1, 1'b1);
    send_pattern(6, 1'b1);
    idle(3, 1'b1);

    // R9: reset mid-stream, byte-aligned pattern unarmed pulses pat only
    do_reset();
    cur_tag = "R9";
    idle(2, 1'b0);
    drive(8'hF6, 1'b0);
    drive(8'h28, 1'b0);
    idle(4, 1'b0);
    for (int i = 0; i < 6; i++) drive(8'($urandom_range(0, 255)), 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule